// File: doc/BRIEF.md
# Indexed-Register Cartridge Banking Controller

This block maps cartridge memory for an 8-bit console CPU bus. The CPU writes through two ports that sit in a low register window: an index port and a data port. A write to the index port picks one of eight 3-bit registers. A write to the data port loads the picked register. Scattered bits of those registers are packed into a 32 KB program bank number, an 8 KB character bank number and a nametable mirroring mode. For each picture-bus access, the mirroring mode turns the nametable quadrant into a CIRAM page select.

Reads from the data port return the picked register in the low bits. The remaining bits come from the last value seen on the CPU data bus (open bus). A variant input selects one of two packings of the character bank. A configuration switch is honoured only in the alternate variant. When it is honoured, it forces bit 2 high on every written byte and narrows the read-back to two driven bits.

Top module: `ibank_ctrl`

## Requirements
- R1: Only addresses from 0x4100 to 0x7FFF are decoded, as `addr & 0xC101`. A result of 0x4100 is the index port and 0x4101 is the data port. Writes that land on neither port change no register.
- R2: A write to the index port stores data bits [2:0] as the register index.
- R3: A write to the data port stores data bits [2:0] into the register chosen by the index. The new value appears on the outputs in the cycle after the write edge.
- R4: A synchronous active-low reset clears the index and all eight registers. After reset the bank outputs and the mirroring mode read 0.
- R5: `prg_bank` equals bits [1:0] of register 5.
- R6: With `variant_alt` low, `chr_bank` is {reg6[1:0], reg4[0], reg2[0]}, with reg6[1] as the MSB.
- R7: With `variant_alt` high, `chr_bank` is {0, reg4[0], reg6[1:0]}. Register 2 has no effect on it.
- R8: `mirror_mode` equals reg7[2:1], and `ciram_page` follows from `ppu_quad`:
  - mode 0 gives page 1 only for quadrant 3;
  - mode 1 gives `ppu_quad[1]` (horizontal);
  - mode 2 gives `ppu_quad[0]` (vertical);
  - mode 3 always gives page 0.
- R9: With the switch not in effect, a data-port address makes `rd_data` equal {open_bus[7:3], selected register[2:0]}.
- R10: Every address other than the data port makes `rd_data` equal `open_bus`.
- R11: With `variant_alt` and `cfg_sw` both high:
  - every written byte is OR'd with 0x04 before use, for index and data writes alike;
  - a data-port read returns {open_bus[7:2], selected register[1:0]}.
- R12: With `variant_alt` low, `cfg_sw` has no effect on writes or reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| open_bus | input | 8 | Last byte seen on the CPU data bus |
| variant_alt | input | 1 | 0: four-bit character packing; 1: three-bit packing with the switch honoured |
| cfg_sw | input | 1 | Configuration switch |
| ppu_quad | input | 2 | Picture-bus address bits [11:10] |
| rd_data | output | 8 | Combinational read data for the current address |
| prg_bank | output | 2 | 32 KB program bank |
| chr_bank | output | 4 | 8 KB character bank |
| mirror_mode | output | 2 | Mirroring mode code |
| ciram_page | output | 1 | Nametable page select |

## Verification
The checker watches several behaviours on every cycle:
- the open-bus pass-through for non-data addresses;
- the open-bus upper bits on data-port reads;
- the fixed page for single-screen mirroring;
- the program bank following a data write to register 5;
- the stability of the outputs across cycles without a write;
- the cleared state after reset.

Other behaviours only the bench scenarios can show:
- the two character-bank packings;
- the forced bit 2 steering index writes into registers 4 to 7;
- the narrowed read-back;
- the switch having no effect in the default variant.

The bench shows these by comparing every output against a model of the register file after random alias-address writes.

// File: rtl/ibank_pkg.sv
// Package: shared types and helpers for the indexed-register banking controller.
// Assumes a 3-bit register file and a 2-bit mirroring code.
package ibank_pkg;

    // Mirroring mode codes as decoded from the mirroring register field.
    typedef enum logic [1:0] {
        MIR_THREE_ONE = 2'd0,
        MIR_HORZ      = 2'd1,
        MIR_VERT      = 2'd2,
        MIR_SINGLE    = 2'd3
    } mirror_e;

    // Page select for one nametable quadrant under a given mode.
    function automatic logic quad_page(input mirror_e mode, input logic [1:0] quad);
        logic pg;
        case (mode)
            MIR_THREE_ONE: pg = (quad == 2'd3);
            MIR_HORZ:      pg = quad[1];
            MIR_VERT:      pg = quad[0];
            default:       pg = 1'b0;
        endcase
        return pg;
    endfunction

endpackage

// File: rtl/ibank_decode.sv
// Module: address window and port decode.
// Assumes the window limits and the mask/match constants come in as parameters.
// The port hits are purely combinational.
module ibank_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] WIN_LO    = 16'h4100,
    parameter logic [15:0] WIN_HI    = 16'h7FFF,
    parameter logic [15:0] DEC_MASK  = 16'hC101,
    parameter logic [15:0] IDX_MATCH = 16'h4100,
    parameter logic [15:0] DAT_MATCH = 16'h4101
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              dat_hit,
    output logic              idx_we,
    output logic              dat_we
);
    logic              in_win;
    logic [ADDR_W-1:0] masked;
    logic              idx_hit;

    // Window and masked-address compare.
    always_comb begin
        in_win  = (addr >= WIN_LO[ADDR_W-1:0]) && (addr <= WIN_HI[ADDR_W-1:0]);
        masked  = addr & DEC_MASK[ADDR_W-1:0];
        idx_hit = in_win && (masked == IDX_MATCH[ADDR_W-1:0]);
        dat_hit = in_win && (masked == DAT_MATCH[ADDR_W-1:0]);
    end

    // Write enables qualified by the strobe.
    always_comb begin
        idx_we = wr && idx_hit;
        dat_we = wr && dat_hit;
    end
endmodule

// File: rtl/ibank_regfile.sv
// Module: index latch plus NREG data registers of REG_W bits.
// Assumes the write data has already been modified by the switch.
// Synchronous active-low reset clears everything.
module ibank_regfile #(
    parameter int NREG  = 8,
    parameter int REG_W = 3,
    parameter int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       idx_we,
    input  logic                       dat_we,
    input  logic [REG_W-1:0]           wval,
    output logic [IDX_W-1:0]           idx_q,
    output logic [NREG-1:0][REG_W-1:0] regs_q
);
    // Index latch update.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= wval[IDX_W-1:0];
    end

    // One storage register per index.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                                        regs_q[g] <= '0;
            else if (dat_we && (idx_q == IDX_W'(g)))           regs_q[g] <= wval;
        end
    end

    if (REG_W > IDX_W) begin : g_unused_w
        logic unused_hi;
        assign unused_hi = ^wval[REG_W-1:IDX_W];
    end
endmodule

// File: rtl/ibank_map.sv
// Module: bank packing and nametable page select.
// Assumes the register bits are already extracted by the top.
// All outputs are combinational.
module ibank_map
    import ibank_pkg::*;
#(
    parameter int PRG_W = 2,
    parameter int CHR_W = 4
) (
    input  logic             variant_alt,
    input  logic             r2b0,
    input  logic             r4b0,
    input  logic [PRG_W-1:0] r5lo,
    input  logic [1:0]       r6lo,
    input  logic [1:0]       r7mid,
    input  logic [1:0]       ppu_quad,
    output logic [PRG_W-1:0] prg_bank,
    output logic [CHR_W-1:0] chr_bank,
    output logic [1:0]       mirror_mode,
    output logic             ciram_page
);
    mirror_e mode;

    // Program bank is taken straight from its register field.
    always_comb prg_bank = r5lo;

    // Character bank packing chosen by the variant.
    always_comb begin
        if (variant_alt) chr_bank = CHR_W'({r4b0, r6lo});
        else             chr_bank = CHR_W'({r6lo, r4b0, r2b0});
    end

    // Mirroring code and the page select for the current quadrant.
    always_comb begin
        mode        = mirror_e'(r7mid);
        mirror_mode = r7mid;
        ciram_page  = quad_page(mode, ppu_quad);
    end
endmodule

// File: rtl/ibank_readback.sv
// Module: read-back mix of register bits and open-bus bits.
// With the switch in effect only NARROW_W bits are driven from the register.
module ibank_readback #(
    parameter int DATA_W   = 8,
    parameter int REG_W    = 3,
    parameter int NARROW_W = 2
) (
    input  logic              dat_hit,
    input  logic              sw_eff,
    input  logic [REG_W-1:0]  sel_reg,
    input  logic [DATA_W-1:0] open_bus,
    output logic [DATA_W-1:0] rd_data
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b < NARROW_W) begin : g_always
            // Bits driven in both read-back widths.
            always_comb rd_data[b] = dat_hit ? sel_reg[b] : open_bus[b];
        end else if (b < REG_W) begin : g_wide
            // Bits driven only when the switch is not in effect.
            always_comb rd_data[b] = (dat_hit && !sw_eff) ? sel_reg[b] : open_bus[b];
        end else begin : g_open
            // Bits always filled from open bus.
            always_comb rd_data[b] = open_bus[b];
        end
    end
endmodule

// File: rtl/ibank_ctrl.sv
// Module: top of the indexed-register cartridge banking controller.
// Decodes the index/data port pair, holds the register file and derives banks,
// mirroring and read-back. Assumes a one-cycle write strobe per CPU write.
module ibank_ctrl #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int NREG     = 8,
    parameter int REG_W    = 3,
    parameter int PRG_W    = 2,
    parameter int CHR_W    = 4,
    parameter int PRG_REG  = 5,
    parameter int MIR_REG  = 7,
    parameter int FORCE_B  = 2,
    parameter int NARROW_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] open_bus,
    input  logic              variant_alt,
    input  logic              cfg_sw,
    input  logic [1:0]        ppu_quad,
    output logic [DATA_W-1:0] rd_data,
    output logic [PRG_W-1:0]  prg_bank,
    output logic [CHR_W-1:0]  chr_bank,
    output logic [1:0]        mirror_mode,
    output logic              ciram_page
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic                       dat_hit, idx_we, dat_we, sw_eff;
    logic [DATA_W-1:0]          wdata_eff;
    logic [IDX_W-1:0]           idx_q;
    logic [NREG-1:0][REG_W-1:0] regs_q;
    logic                       unused_wdata;

    // Switch honoured only in the alternate variant; it forces one data bit.
    always_comb begin
        sw_eff    = variant_alt && cfg_sw;
        wdata_eff = cpu_wdata;
        if (sw_eff) wdata_eff[FORCE_B] = 1'b1;
    end
    assign unused_wdata = ^wdata_eff[DATA_W-1:REG_W];

    ibank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (cpu_addr),
        .wr      (cpu_wr),
        .dat_hit (dat_hit),
        .idx_we  (idx_we),
        .dat_we  (dat_we)
    );

    ibank_regfile #(.NREG(NREG), .REG_W(REG_W), .IDX_W(IDX_W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_we (idx_we),
        .dat_we (dat_we),
        .wval   (wdata_eff[REG_W-1:0]),
        .idx_q  (idx_q),
        .regs_q (regs_q)
    );

    ibank_map #(.PRG_W(PRG_W), .CHR_W(CHR_W)) u_map (
        .variant_alt (variant_alt),
        .r2b0        (regs_q[2][0]),
        .r4b0        (regs_q[4][0]),
        .r5lo        (regs_q[PRG_REG][PRG_W-1:0]),
        .r6lo        (regs_q[6][1:0]),
        .r7mid       (regs_q[MIR_REG][2:1]),
        .ppu_quad    (ppu_quad),
        .prg_bank    (prg_bank),
        .chr_bank    (chr_bank),
        .mirror_mode (mirror_mode),
        .ciram_page  (ciram_page)
    );

    ibank_readback #(.DATA_W(DATA_W), .REG_W(REG_W), .NARROW_W(NARROW_W)) u_rb (
        .dat_hit  (dat_hit),
        .sw_eff   (sw_eff),
        .sel_reg  (regs_q[idx_q]),
        .open_bus (open_bus),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/ibank_ctrl_chk.sv
// Module: checker for ibank_ctrl, attached with bind.
// Decodes the data port on its own, independently of the design.
module ibank_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_wr,
    input logic [7:0]  open_bus,
    input logic [1:0]  ppu_quad,
    input logic [7:0]  rd_data,
    input logic [1:0]  prg_bank,
    input logic [3:0]  chr_bank,
    input logic [1:0]  mirror_mode,
    input logic        ciram_page,
    input logic [2:0]  idx_q
);
    logic dport;
    assign dport = (cpu_addr >= 16'h4100) && (cpu_addr <= 16'h7FFF) &&
                   ((cpu_addr & 16'hC101) == 16'h4101);

    // R4: the cycle after reset shows cleared banks and mode.
    p_reset_clear_r4: assert property (@(posedge clk)
        !rst_n |=> (prg_bank == 2'd0 && mirror_mode == 2'd0));

    // R5: a data write to register 5 sets the program bank.
    p_prg_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && dport && idx_q == 3'd5) |=> (prg_bank == $past(cpu_wdata[1:0])));

    // R10: non-data addresses pass open bus through unchanged.
    p_open_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dport |-> (rd_data == open_bus));

    // R9: data-port reads keep the top five bits from open bus.
    p_rd_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dport |-> (rd_data[7:3] == open_bus[7:3]));

    // R8: single-screen mode always selects page 0.
    p_single_screen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mirror_mode == 2'd3) |-> (ciram_page == 1'b0));

    // R3: without a write strobe the program bank and mode hold.
    p_hold_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> ($stable(prg_bank) && $stable(mirror_mode)));

    logic unused_chk;
    assign unused_chk = ^{ppu_quad, chr_bank};
endmodule

bind ibank_ctrl ibank_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .cpu_wr      (cpu_wr),
    .open_bus    (open_bus),
    .ppu_quad    (ppu_quad),
    .rd_data     (rd_data),
    .prg_bank    (prg_bank),
    .chr_bank    (chr_bank),
    .mirror_mode (mirror_mode),
    .ciram_page  (ciram_page),
    .idx_q       (idx_q)
);

// File: tb/ibank_ctrl_test.sv
`timescale 1ns/1ps
module ibank_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [7:0]  open_bus = 8'h00;
    logic        variant_alt = 1'b0;
    logic        cfg_sw = 1'b0;
    logic [1:0]  ppu_quad = 2'd0;
    logic [7:0]  rd_data;
    logic [1:0]  prg_bank;
    logic [3:0]  chr_bank;
    logic [1:0]  mirror_mode;
    logic        ciram_page;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] m_idx;
    logic [2:0] m_reg [8];

    always #2.5 clk = ~clk;

    ibank_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .open_bus(open_bus), .variant_alt(variant_alt),
        .cfg_sw(cfg_sw), .ppu_quad(ppu_quad), .rd_data(rd_data),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror_mode(mirror_mode),
        .ciram_page(ciram_page)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_dport(input logic [15:0] a);
        return (a >= 16'h4100) && (a <= 16'h7FFF) && ((a & 16'hC101) == 16'h4101);
    endfunction
    function automatic bit is_iport(input logic [15:0] a);
        return (a >= 16'h4100) && (a <= 16'h7FFF) && ((a & 16'hC101) == 16'h4100);
    endfunction
    function automatic logic [3:0] exp_chr();
        if (variant_alt) return {1'b0, m_reg[4][0], m_reg[6][1:0]};
        return {m_reg[6][1:0], m_reg[4][0], m_reg[2][0]};
    endfunction
    function automatic logic exp_page(input logic [1:0] q);
        case (m_reg[7][2:1])
            2'd0: return q == 2'd3;
            2'd1: return q[1];
            2'd2: return q[0];
            default: return 1'b0;
        endcase
    endfunction
    function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic [7:0] ob);
        if (!is_dport(a)) return ob;
        if (variant_alt && cfg_sw) return {ob[7:2], m_reg[m_idx][1:0]};
        return {ob[7:3], m_reg[m_idx]};
    endfunction
    function automatic logic [15:0] alias_addr(input bit dat);
        logic [15:0] r;
        r = 16'($urandom);
        return {2'b01, r[13:9], 1'b1, r[7:1], dat};
    endfunction

    // One write cycle; the model follows the requirements.
    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] e;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        e = d | ((variant_alt && cfg_sw) ? 8'h04 : 8'h00);
        if (is_iport(a)) m_idx = e[2:0];
        else if (is_dport(a)) m_reg[m_idx] = e[2:0];
    endtask

    task automatic check_all(input string tag);
        check({tag, " R5 prg"}, prg_bank, m_reg[5][1:0]);
        check({tag, " R6/R7 chr"}, chr_bank, exp_chr());
        check({tag, " R8 mode"}, mirror_mode, m_reg[7][2:1]);
    endtask

    task automatic check_read(input logic [15:0] a, input logic [7:0] ob, input string req);
        cpu_addr = a; open_bus = ob;
        #0.5;
        check(req, rd_data, exp_rd(a, ob));
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_idx = '0;
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reset state.
        check("R4 prg", prg_bank, 0);
        check("R4 chr", chr_bank, 0);
        check("R4 mode", mirror_mode, 0);
        check_read(16'h4101, 8'hA5, "R4 R9 readback zero");

        // R2/R3/R5 through aliased ports.
        do_write(16'h4102, 8'hFD); // index 5
        do_write(16'h7F01, 8'h03);
        check("R5 prg=3", prg_bank, 2'd3);
        check_read(16'h5103, 8'hFF, "R9 readback reg5");
        // R1 writes off the ports change nothing.
        do_write(16'h4001, 8'h00);
        do_write(16'hC101, 8'h00);
        do_write(16'h0101, 8'h00);
        check("R1 no effect prg", prg_bank, 2'd3);
        check_read(16'h4100, 8'h3C, "R10 index port reads open bus");
        check_read(16'h8101, 8'hC3, "R10 outside window");

        // R6 default packing.
        do_write(16'h4100, 8'h02); do_write(16'h4101, 8'h01);
        do_write(16'h4100, 8'h04); do_write(16'h4101, 8'h01);
        do_write(16'h4100, 8'h06); do_write(16'h4101, 8'h02);
        check("R6 chr default", chr_bank, 4'hB);
        // R7 alternate packing ignores register 2.
        variant_alt = 1'b1;
        #0.5;
        check("R7 chr alt", chr_bank, 4'h6);

        // R8 all modes, all quadrants.
        variant_alt = 1'b0;
        for (int m = 0; m < 4; m++) begin
            do_write(16'h4100, 8'h07);
            do_write(16'h4101, 8'(m << 1));
            for (int q = 0; q < 4; q++) begin
                ppu_quad = 2'(q);
                #0.5;
                check("R8 ciram", ciram_page, exp_page(2'(q)));
            end
        end

        // R12 switch ignored in default variant.
        cfg_sw = 1'b1;
        do_write(16'h4100, 8'h01);
        do_write(16'h4101, 8'h00);
        check_read(16'h4101, 8'hFF, "R12 readback wide, no force");
        // R11 switch forces bit 2: index 0 becomes 4.
        variant_alt = 1'b1;
        do_write(16'h4100, 8'h00);
        do_write(16'h4101, 8'h00);
        check("R11 forced reg4 chr", chr_bank, {1'b0, 1'b0, m_reg[6][1:0]});
        check_read(16'h4101, 8'h00, "R11 narrow readback");
        check_read(16'h4101, 8'hFF, "R11 narrow readback open");

        // Constrained random mix.
        for (int it = 0; it < 1500; it++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 3)      do_write(alias_addr(1'b0), 8'($urandom));
            else if (op < 7) do_write(alias_addr(1'b1), 8'($urandom));
            else if (op < 8) begin
                @(negedge clk);
                variant_alt = 1'($urandom); cfg_sw = 1'($urandom);
            end else do_write(16'($urandom), 8'($urandom));
            ppu_quad = 2'($urandom);
            #0.5;
            check_all("rand R3");
            check("rand R8 ciram", ciram_page, exp_page(ppu_quad));
            check_read(($urandom % 2) ? alias_addr(1'b1) : 16'($urandom), 8'($urandom),
                       "rand R9/R10/R11 read");
        end

        // R4 reset again clears.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_idx = '0;
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        check_all("R4 reset again");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule